// File: doc/BRIEF.md
# Fast A20 and alternate reset port

This block is an 8-bit legacy control register decoded at I/O address 92h. Software uses it instead of the slower keyboard controller for two things: forcing address line 20 open and kicking the CPU into reset. A configuration bit held outside the block decides whether the port answers at all. The register drives an A20 level, which is ORed with the keyboard controller's A20 request to form the mask output. A 0-to-1 write of the reset bit starts a timed active-low reset pulse that runs after a fixed delay. That pulse is ANDed with the keyboard controller's active-low reset, and the result leaves the block with a selectable polarity.

The bus side is a plain register strobe interface. There is no data stream, so there is no valid/ready handshake. A write takes effect at the clock edge where `io_wr` is sampled high. Read data is combinational while `io_rd` is held. The delay and the pulse width are cycle counts derived from the clock frequency parameter. By default that is 1 MHz, which gives 14 cycles of delay and 6 cycles of pulse.

Top module: `a20rst_port`

## Requirements
- R1: After system reset the register reads 24h, `a20_alt` is 0 and `alt_rst_n` is 1.
- R2: A write changes nothing unless `port_en` is 1 and `io_addr` equals 92h. While the port is disabled, a write of 03h leaves `a20_alt` at 0 and produces no reset pulse.
- R3: Read data is {bits 7:6 = 00, bit 5 = 1, bits 4:3 = 00, bit 2 = 1, bit 1 = A20 bit, bit 0 = reset bit}. The written values of bits 7:2 have no effect.
- R4: Written bit 1 is driven on `a20_alt` from the cycle after the write.
- R5: `a20_mask` is 1 when `kbc_a20` or `a20_alt` is 1, and is 0 only when both are 0.
- R6: A write that moves bit 0 from 0 to 1 keeps `alt_rst_n` high for DELAY_CYC cycles after the write edge. It then drives `alt_rst_n` low for exactly PULSE_CYC cycles (14 and 6 at the default clock).
- R7: Writing 1 to bit 0 while it already holds 1 starts no pulse. Writing 0 and then 1 starts a new one.
- R8: Once a sequence has begun, writing 0 to bit 0 during the delay or the pulse does not shorten or cancel it.
- R9: System reset aborts any running sequence, clears bit 0, and holds `alt_rst_n` high.
- R10: `sys_rst_out` is the AND of `alt_rst_n` and `kbc_rst_n`. It is passed through unchanged when `rst_pol` is 0 and inverted when `rst_pol` is 1.
- R11: `io_rdata` is 00h unless `io_rd` is 1, `port_en` is 1 and `io_addr` equals 92h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, zero when not an enabled read of 92h |
| port_en | input | 1 | Port enable from external configuration |
| kbc_a20 | input | 1 | A20 request from the keyboard controller |
| kbc_rst_n | input | 1 | Active-low reset from the keyboard controller |
| rst_pol | input | 1 | Output polarity of the combined reset, 1 inverts |
| a20_alt | output | 1 | Register-driven A20 level |
| a20_mask | output | 1 | Combined A20 gate |
| alt_rst_n | output | 1 | Timed active-low alternate reset pulse |
| sys_rst_out | output | 1 | Combined reset after the polarity select |

## Verification
The bench measures the exact cycle in which the reset pulse falls and how long it stays low. A design with a delay or width that is off by one would move the edge or change the count. It rewrites 1 over a set reset bit, where a design that triggers on level rather than on the 0-to-1 transition would fire a second pulse. It clears the bit in the middle of a delay, where a design that ties the sequence to the bit would cut the pulse short. It also drives writes with the port disabled and applies system reset mid-sequence, where a leaky enable or a sequencer that survives reset would show up as a changed A20 level or as a pulse.

// File: rtl/a20rst_pkg.sv
`timescale 1ns/1ps
package a20rst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_PULSE = 2'd2
  } seq_state_e;

  // Fixed pattern of the reserved read-back bits 7:2
  localparam logic [5:0] RSVD_RD = 6'b001001;

  // Round a duration up to whole clock cycles, never below one
  function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = hz * ns;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/a20rst_regs.sv
`timescale 1ns/1ps
module a20rst_regs #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              port_en,
  output logic              a20_q,
  output logic              arm_q,
  output logic              arm_start,
  output logic [7:0]        io_rdata
);
  import a20rst_pkg::*;

  logic hit;
  logic wr_hit;
  logic unused_rsvd;

  assign hit         = port_en && (io_addr == PORT_ADDR);
  assign wr_hit      = hit && io_wr;
  assign unused_rsvd = ^io_wdata[7:2];

  // A new sequence is requested only on a 0 -> 1 transition of the reset bit
  assign arm_start = wr_hit && io_wdata[0] && !arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a20_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (wr_hit) begin
      a20_q <= io_wdata[1];
      arm_q <= io_wdata[0];
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (hit && io_rd) io_rdata = {RSVD_RD, a20_q, arm_q};
  end

endmodule

// File: rtl/a20rst_seq.sv
`timescale 1ns/1ps
module a20rst_seq #(
  parameter int unsigned DELAY_CYC = 14,
  parameter int unsigned PULSE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic alt_rst_n
);
  import a20rst_pkg::*;

  localparam int unsigned MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC) + 1;
  typedef logic [CNT_W-1:0] cnt_t;

  seq_state_e state_q;
  cnt_t       cnt_q;

  // Once started, the sequence ignores the register bit until it returns to idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_DELAY;
          cnt_q   <= cnt_t'(DELAY_CYC - 1);
        end
        SEQ_DELAY: if (cnt_q == '0) begin
          state_q <= SEQ_PULSE;
          cnt_q   <= cnt_t'(PULSE_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        SEQ_PULSE: if (cnt_q == '0) begin
          state_q <= SEQ_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign alt_rst_n = (state_q != SEQ_PULSE);

endmodule

// File: rtl/a20rst_combine.sv
`timescale 1ns/1ps
module a20rst_combine (
  input  logic kbc_a20,
  input  logic a20_alt,
  input  logic kbc_rst_n,
  input  logic alt_rst_n,
  input  logic rst_pol,
  output logic a20_mask,
  output logic sys_rst_out
);
  logic both_n;

  assign a20_mask    = kbc_a20 | a20_alt;
  assign both_n      = alt_rst_n & kbc_rst_n;
  assign sys_rst_out = rst_pol ? ~both_n : both_n;

endmodule

// File: rtl/a20rst_port.sv
`timescale 1ns/1ps
module a20rst_port #(
  parameter int unsigned    ADDR_W    = 16,
  parameter logic [15:0]    PORT_ADDR = 16'h0092,
  parameter longint unsigned CLK_HZ   = 1_000_000,
  parameter longint unsigned DELAY_NS = 14_000,
  parameter longint unsigned PULSE_NS = 6_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              port_en,
  input  logic              kbc_a20,
  input  logic              kbc_rst_n,
  input  logic              rst_pol,
  output logic              a20_alt,
  output logic              a20_mask,
  output logic              alt_rst_n,
  output logic              sys_rst_out
);
  import a20rst_pkg::*;

  localparam int unsigned DELAY_CYC = ns_to_cycles(CLK_HZ, DELAY_NS);
  localparam int unsigned PULSE_CYC = ns_to_cycles(CLK_HZ, PULSE_NS);

  logic arm_q;
  logic arm_start;
  logic unused_arm;

  assign unused_arm = arm_q;

  a20rst_regs #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(ADDR_W'(PORT_ADDR))
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .port_en  (port_en),
    .a20_q    (a20_alt),
    .arm_q    (arm_q),
    .arm_start(arm_start),
    .io_rdata (io_rdata)
  );

  a20rst_seq #(
    .DELAY_CYC(DELAY_CYC),
    .PULSE_CYC(PULSE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (arm_start),
    .alt_rst_n(alt_rst_n)
  );

  a20rst_combine u_comb (
    .kbc_a20    (kbc_a20),
    .a20_alt    (a20_alt),
    .kbc_rst_n  (kbc_rst_n),
    .alt_rst_n  (alt_rst_n),
    .rst_pol    (rst_pol),
    .a20_mask   (a20_mask),
    .sys_rst_out(sys_rst_out)
  );

endmodule

// File: rtl/a20rst_port_chk.sv
`timescale 1ns/1ps
module a20rst_port_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0092,
  parameter int unsigned PULSE_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              port_en,
  input logic              kbc_rst_n,
  input logic              rst_pol,
  input logic              a20_alt,
  input logic              alt_rst_n,
  input logic              sys_rst_out
);
  logic hit;
  assign hit = port_en && (io_addr == ADDR_W'(PORT_ADDR));

  AST_A20_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && io_wr) |=> (a20_alt == $past(io_wdata[1]))); // R4

  AST_DISABLED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !port_en) |=> $stable(a20_alt)); // R2

  AST_RSVD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && io_rd) |-> (io_rdata[7:2] == 6'b001001)); // R3

  AST_NO_IMMEDIATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && io_wr && io_wdata[0] && alt_rst_n) |=> alt_rst_n); // R6

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> alt_rst_n); // R9

  AST_KBC_RESET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !kbc_rst_n |-> (sys_rst_out == rst_pol)); // R10

  generate
    if (PULSE_CYC >= 2) begin : g_width
      AST_PULSE_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alt_rst_n) |=> !alt_rst_n); // R8
    end
  endgenerate

endmodule

bind a20rst_port a20rst_port_chk #(
  .ADDR_W   (ADDR_W),
  .PORT_ADDR(PORT_ADDR),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_rdata   (io_rdata),
  .port_en    (port_en),
  .kbc_rst_n  (kbc_rst_n),
  .rst_pol    (rst_pol),
  .a20_alt    (a20_alt),
  .alt_rst_n  (alt_rst_n),
  .sys_rst_out(sys_rst_out)
);

// File: tb/a20rst_port_bench.sv
`timescale 1ns/1ps
module a20rst_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_DELAY  = 14;
  localparam int EXP_PULSE  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        port_en = 1'b0;
  logic        kbc_a20 = 1'b0;
  logic        kbc_rst_n = 1'b1;
  logic        rst_pol = 1'b0;
  logic        a20_alt, a20_mask, alt_rst_n, sys_rst_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string req; } rd_item_t;
  rd_item_t rd_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  a20rst_port u_a20rst_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .port_en(port_en),
    .kbc_a20(kbc_a20), .kbc_rst_n(kbc_rst_n), .rst_pol(rst_pol),
    .a20_alt(a20_alt), .a20_mask(a20_mask), .alt_rst_n(alt_rst_n),
    .sys_rst_out(sys_rst_out)
  );

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // Driver: pushes the expected read value, the monitor compares it
  task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    rd_q.push_back('{exp: exp, req: req});
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  // Monitor: samples read data a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (io_rd && rd_q.size() > 0) begin
      rd_item_t it;
      it = rd_q.pop_front();
      check(int'(io_rdata), int'(it.exp), it.req);
    end
  end

  // Samples n = 1..len at falling edges, n = 1 is the one right after the write edge
  task automatic measure(input int len, output int first_low, output int lows, output int sys_lows);
    first_low = 0; lows = 0; sys_lows = 0;
    for (int n = 1; n <= len; n++) begin
      if (n > 1) @(negedge clk);
      if (alt_rst_n === 1'b0) begin
        lows++;
        if (first_low == 0) first_low = n;
      end
      if (sys_rst_out === 1'b0) sys_lows++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int fl, lw, sl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(a20_alt, 0, "R1 a20_alt after reset");
    check(alt_rst_n, 1, "R1 alt_rst_n after reset");
    port_en = 1'b1;
    io_read(16'h0092, 8'h24, "R1 reset value");
    // R2 disabled port ignores writes, R11 zero read data
    port_en = 1'b0;
    io_write(16'h0092, 8'h03);
    measure(25, fl, lw, sl);
    check(lw, 0, "R2 no pulse while disabled");
    check(a20_alt, 0, "R2 a20 unchanged while disabled");
    io_read(16'h0092, 8'h00, "R11 disabled read is zero");
    port_en = 1'b1;
    io_write(16'h0093, 8'h02);
    check(a20_alt, 0, "R2 wrong address ignored");
    io_read(16'h0093, 8'h00, "R11 other address read is zero");
    io_read(16'h0092, 8'h24, "R2 register unchanged");
    // R4 and R3
    io_write(16'h0092, 8'hDA);
    check(a20_alt, 1, "R4 a20 driven high");
    io_read(16'h0092, 8'h26, "R3 reserved bits fixed");
    // R5 mask combinations
    kbc_a20 = 0; #1 check(a20_mask, 1, "R5 alt=1 kbc=0");
    kbc_a20 = 1; #1 check(a20_mask, 1, "R5 alt=1 kbc=1");
    io_write(16'h0092, 8'h00);
    check(a20_alt, 0, "R4 a20 driven low");
    #1 check(a20_mask, 1, "R5 alt=0 kbc=1");
    kbc_a20 = 0; #1 check(a20_mask, 0, "R5 alt=0 kbc=0");
    // R6 pulse timing, R10 pass-through with rst_pol=0
    io_write(16'h0092, 8'h01);
    measure(40, fl, lw, sl);
    check(fl, EXP_DELAY + 1, "R6 pulse start cycle");
    check(lw, EXP_PULSE, "R6 pulse width");
    check(sl, EXP_PULSE, "R10 pulse reaches sys_rst_out");
    io_read(16'h0092, 8'h25, "R3 reset bit reads back");
    // R7 rewrite 1 does nothing, then re-arm
    io_write(16'h0092, 8'h01);
    measure(40, fl, lw, sl);
    check(lw, 0, "R7 no pulse on rewrite of 1");
    io_write(16'h0092, 8'h00);
    io_write(16'h0092, 8'h01);
    measure(40, fl, lw, sl);
    check(fl, EXP_DELAY + 1, "R7 re-armed pulse start");
    check(lw, EXP_PULSE, "R7 re-armed pulse width");
    // R8 clearing the bit mid-delay does not cut the sequence
    io_write(16'h0092, 8'h00);
    io_write(16'h0092, 8'h01);
    fork
      measure(40, fl, lw, sl);
      begin repeat (4) @(negedge clk); io_write(16'h0092, 8'h00); end
    join
    check(fl, EXP_DELAY + 1, "R8 start after mid-delay clear");
    check(lw, EXP_PULSE, "R8 width after mid-delay clear");
    // R8 clearing during the pulse
    io_write(16'h0092, 8'h01);
    fork
      measure(40, fl, lw, sl);
      begin repeat (EXP_DELAY + 1) @(negedge clk); io_write(16'h0092, 8'h00); end
    join
    check(lw, EXP_PULSE, "R8 width after mid-pulse clear");
    // R9 reset aborts a running sequence
    io_write(16'h0092, 8'h01);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    measure(30, fl, lw, sl);
    check(lw, 0, "R9 no pulse after reset abort");
    io_read(16'h0092, 8'h24, "R9 reset bit cleared");
    // R10 keyboard reset and polarity
    kbc_rst_n = 0; rst_pol = 0; #1 check(sys_rst_out, 0, "R10 kbc reset pol0");
    rst_pol = 1; #1 check(sys_rst_out, 1, "R10 kbc reset pol1");
    kbc_rst_n = 1; #1 check(sys_rst_out, 0, "R10 idle pol1");
    rst_pol = 0; #1 check(sys_rst_out, 1, "R10 idle pol0");
    repeat (3) @(negedge clk);
    wait (rd_q.size() == 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule